// File: doc/BRIEF.md
# Serial Synchronization Message Framer

This block is the two ends of one serial link in a tree-shaped synchronization network. Both ends run on the same network clock and move one bit per cycle. The transmit side takes a parallel message through a valid/ready handshake. A message is a 3-bit operation code plus a data field. The transmit side then drives the frame onto a single wire: a start bit of 1, the three code bits with bit 0 first, the data bits with the least significant bit first, and a stop bit of 0. No length field travels on the wire. The operation code alone fixes how many data bits follow, anywhere from none to 76.

The receive side watches an idle-low line and recognises a start bit once it has seen the line at 0. It collects the code and works out the data length from it, then gathers that many data bits and checks the stop bit. It presents the code, the zero-extended data and the length behind a valid strobe that waits for the consumer. A frame that carries a reserved code is dropped without a report. A bad stop bit produces a one-cycle framing-error pulse and no message. The barrier-create length depends on how many tree levels remain above the link, which is set by the parameter `MASK_LEVELS` (0 to 8, default 3).

Top module: `syncmsg_link`

## Requirements
- R1: While the transmitter is not busy, `tx_line` is 0.
- R2: An accepted message produces, from the next cycle on, a 1 start bit, then code bits C0, C1, C2, then the data bits LSB first, then a 0 stop bit. `tx_busy` is high from the start-bit cycle through the stop-bit cycle, so it lasts 5+len cycles. `tx_ready` is low throughout, and a `tx_valid` raised while busy is ignored.
- R3: Codes and data lengths: 000 reset has 0 bits. 001 barrier create has 8+8*MASK_LEVELS bits (32 by default). 010 barrier reached has 8 bits. 011 broadcast has 76 bits. 100 lock acquire has 17 bits (8-bit lock ID, then 9-bit node ID). 101 lock release has 8 bits. The receiver reports this length on `rx_len` together with the code.
- R4: The receiver returns the code and the data bits in their original positions, with every data bit at or above the length set to 0. Over a direct loopback, `rx_valid` rises 5+len cycles after the accepting edge. `rx_valid` then holds until a cycle with `rx_ready` high.
- R5: Codes 110 and 111 are reserved. The transmitter sends them with no data bits, and the receiver drops them with neither `rx_valid` nor `rx_frame_err`.
- R6: When the stop-bit position carries a 1, `rx_frame_err` pulses for exactly one cycle and no message is delivered.
- R7: After any frame ends, the receiver starts a new frame only after it has sampled the line at 0 for at least one cycle. A line held at 1 never starts a frame.
- R8: During and straight after reset, `tx_ready`=1, `tx_busy`=0, `tx_line`=0, `rx_valid`=0 and `rx_frame_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared network clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | input | 1 | Message offered for sending |
| tx_ready | output | 1 | Transmitter can take a message |
| tx_cmd | input | 3 | Operation code to send |
| tx_data | input | 76 | Data field, LSB sent first; bits above the length are unused |
| tx_busy | output | 1 | Frame on the wire, start through stop bit |
| tx_line | output | 1 | Serial output, idle 0 |
| rx_line | input | 1 | Serial input, idle 0 |
| rx_valid | output | 1 | Received message waiting |
| rx_ready | input | 1 | Consumer takes the waiting message |
| rx_cmd | output | 3 | Received operation code |
| rx_data | output | 76 | Received data, zero above the length |
| rx_len | output | 7 | Number of data bits that arrived |
| rx_frame_err | output | 1 | One-cycle pulse on a bad stop bit |

## Verification
A table of messages covering all six defined codes goes through a loopback. Each data word has 1s above its own length, so truncation, bit order and zero-filling show up as distinct faults. Busy length and latency are counted per code, which separates an off-by-one in the length decode from one in the framing counters. Hand-driven line patterns supply the cases the transmitter cannot produce:
- a stop bit of 1;
- a line stuck high after that bad stop bit;
- a good frame after the line returns to idle.

These tell error reporting apart from silent re-synchronisation. Reserved codes, a second offer while busy, and a consumer that holds off for many cycles separate dropping, ignoring and holding.

// File: rtl/syncmsg_pkg.sv
package syncmsg_pkg;

    localparam int unsigned CMD_W     = 3;
    localparam int unsigned DATA_MAX  = 76;
    localparam int unsigned LEN_W     = $clog2(DATA_MAX + 1);
    localparam int unsigned CNT_W     = $clog2(CMD_W + DATA_MAX + 1);
    localparam int unsigned ID_BITS   = 8;
    localparam int unsigned NODE_BITS = 9;

    typedef enum logic [CMD_W-1:0] {
        OP_RESET    = 3'b000,
        OP_BAR_MAKE = 3'b001,
        OP_BAR_HIT  = 3'b010,
        OP_BCAST    = 3'b011,
        OP_LOCK_GET = 3'b100,
        OP_LOCK_PUT = 3'b101,
        OP_RSV6     = 3'b110,
        OP_RSV7     = 3'b111
    } op_e;

    // Data length is a pure function of the code; nothing on the wire says it.
    function automatic logic [LEN_W-1:0] op_data_len(input logic [CMD_W-1:0] op,
                                                     input int unsigned levels);
        case (op)
            OP_BAR_MAKE:            return LEN_W'(ID_BITS + ID_BITS * levels);
            OP_BAR_HIT, OP_LOCK_PUT: return LEN_W'(ID_BITS);
            OP_BCAST:               return LEN_W'(DATA_MAX);
            OP_LOCK_GET:            return LEN_W'(ID_BITS + NODE_BITS);
            default:                return '0;
        endcase
    endfunction

    function automatic logic op_reserved(input logic [CMD_W-1:0] op);
        return op[2] & op[1];
    endfunction

endpackage

// File: rtl/syncmsg_tx.sv
module syncmsg_tx
    import syncmsg_pkg::*;
#(
    parameter int unsigned MASK_LEVELS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [CMD_W-1:0]    in_op,
    input  logic [DATA_MAX-1:0] in_data,
    output logic                busy,
    output logic                line
);

    localparam int unsigned SH_W = CMD_W + DATA_MAX;

    typedef enum logic [1:0] {TX_IDLE, TX_SEND, TX_STOP} tx_st_e;

    typedef struct packed {
        tx_st_e           st;
        logic             line;
        logic [SH_W-1:0]  sh;
        logic [CNT_W-1:0] left;
    } tx_s;

    tx_s q, d;

    always_comb begin
        d = q;
        case (q.st)
            TX_IDLE: begin
                d.line = 1'b0;
                if (in_valid) begin
                    d.st   = TX_SEND;
                    d.line = 1'b1;                 // start bit
                    d.sh   = {in_data, in_op};     // code leaves first, bit 0 first
                    d.left = CNT_W'(CMD_W) + CNT_W'(op_data_len(in_op, MASK_LEVELS));
                end
            end
            TX_SEND: begin
                if (q.left != '0) begin
                    d.line = q.sh[0];
                    d.sh   = q.sh >> 1;
                    d.left = q.left - CNT_W'(1);
                end else begin
                    d.line = 1'b0;                 // stop bit
                    d.st   = TX_STOP;
                end
            end
            TX_STOP: begin
                d.line = 1'b0;
                d.st   = TX_IDLE;
            end
            default: d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: TX_IDLE, default: '0};
        else        q <= d;
    end

    assign in_ready = (q.st == TX_IDLE);
    assign busy     = (q.st != TX_IDLE);
    assign line     = q.line;

endmodule

// File: rtl/syncmsg_rx.sv
module syncmsg_rx
    import syncmsg_pkg::*;
#(
    parameter int unsigned MASK_LEVELS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                line,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [CMD_W-1:0]    out_op,
    output logic [DATA_MAX-1:0] out_data,
    output logic [LEN_W-1:0]    out_len,
    output logic                frame_err
);

    typedef enum logic [1:0] {RX_IDLE, RX_CMD, RX_DATA, RX_STOP} rx_st_e;

    typedef struct packed {
        rx_st_e              st;
        logic                armed;
        logic [CNT_W-1:0]    idx;
        logic [CMD_W-1:0]    op;
        logic [LEN_W-1:0]    len;
        logic [DATA_MAX-1:0] data;
        logic                ov;
        logic [CMD_W-1:0]    oop;
        logic [DATA_MAX-1:0] odata;
        logic [LEN_W-1:0]    olen;
        logic                err;
    } rx_s;

    rx_s q, d;
    logic [LEN_W-1:0] len_n;

    always_comb begin
        d     = q;
        len_n = '0;
        d.err = 1'b0;
        if (out_ready) d.ov = 1'b0;
        case (q.st)
            RX_IDLE: begin
                d.armed = ~line;
                if (line && q.armed) begin
                    d.st   = RX_CMD;
                    d.idx  = '0;
                    d.data = '0;
                end
            end
            RX_CMD: begin
                d.op = {line, q.op[CMD_W-1:1]};
                if (q.idx == CNT_W'(CMD_W - 1)) begin
                    len_n = op_data_len({line, q.op[CMD_W-1:1]}, MASK_LEVELS);
                    d.len = len_n;
                    d.idx = '0;
                    d.st  = (len_n == '0) ? RX_STOP : RX_DATA;
                end else begin
                    d.idx = q.idx + CNT_W'(1);
                end
            end
            RX_DATA: begin
                for (int i = 0; i < DATA_MAX; i++) begin
                    if (q.idx == CNT_W'(i)) d.data[i] = line;
                end
                if (q.idx + CNT_W'(1) == CNT_W'(q.len)) d.st = RX_STOP;
                else                                    d.idx = q.idx + CNT_W'(1);
            end
            RX_STOP: begin
                d.st    = RX_IDLE;
                d.armed = 1'b0;
                if (line) begin
                    d.err = 1'b1;
                end else if (!op_reserved(q.op)) begin
                    d.ov    = 1'b1;
                    d.oop   = q.op;
                    d.odata = q.data;
                    d.olen  = q.len;
                end
            end
            default: d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: RX_IDLE, default: '0};
        else        q <= d;
    end

    assign out_valid = q.ov;
    assign out_op    = q.oop;
    assign out_data  = q.odata;
    assign out_len   = q.olen;
    assign frame_err = q.err;

endmodule

// File: rtl/syncmsg_link.sv
module syncmsg_link
    import syncmsg_pkg::*;
#(
    parameter int unsigned MASK_LEVELS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tx_valid,
    output logic                tx_ready,
    input  logic [CMD_W-1:0]    tx_cmd,
    input  logic [DATA_MAX-1:0] tx_data,
    output logic                tx_busy,
    output logic                tx_line,
    input  logic                rx_line,
    output logic                rx_valid,
    input  logic                rx_ready,
    output logic [CMD_W-1:0]    rx_cmd,
    output logic [DATA_MAX-1:0] rx_data,
    output logic [LEN_W-1:0]    rx_len,
    output logic                rx_frame_err
);

    syncmsg_tx #(.MASK_LEVELS(MASK_LEVELS)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (tx_valid),
        .in_ready (tx_ready),
        .in_op    (tx_cmd),
        .in_data  (tx_data),
        .busy     (tx_busy),
        .line     (tx_line)
    );

    syncmsg_rx #(.MASK_LEVELS(MASK_LEVELS)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .line      (rx_line),
        .out_valid (rx_valid),
        .out_ready (rx_ready),
        .out_op    (rx_cmd),
        .out_data  (rx_data),
        .out_len   (rx_len),
        .frame_err (rx_frame_err)
    );

endmodule

// File: rtl/syncmsg_link_chk.sv
module syncmsg_link_chk
    import syncmsg_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                tx_busy,
    input logic                tx_line,
    input logic                rx_valid,
    input logic                rx_ready,
    input logic [CMD_W-1:0]    rx_cmd,
    input logic [DATA_MAX-1:0] rx_data,
    input logic [LEN_W-1:0]    rx_len,
    input logic                rx_frame_err
);

    assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> !tx_line);

    assert_start_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> tx_line);

    assert_stop_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_busy) |-> !$past(tx_line));

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && !rx_ready |=> rx_valid);

    assert_zero_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ((rx_data >> rx_len) == '0));

    assert_no_reserved_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !(rx_cmd[2] && rx_cmd[1]));

    assert_err_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_frame_err |=> !rx_frame_err);

endmodule

bind syncmsg_link syncmsg_link_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_busy      (tx_busy),
    .tx_line      (tx_line),
    .rx_valid     (rx_valid),
    .rx_ready     (rx_ready),
    .rx_cmd       (rx_cmd),
    .rx_data      (rx_data),
    .rx_len       (rx_len),
    .rx_frame_err (rx_frame_err)
);

// File: tb/syncmsg_link_test.sv
`timescale 1ns/1ps
module syncmsg_link_test;
    import syncmsg_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_valid = 1'b0;
    logic [2:0]  tx_cmd = '0;
    logic [75:0] tx_data = '0;
    logic        rx_ready = 1'b0;
    logic        man_sel = 1'b0;
    logic        man_line = 1'b0;
    logic        tx_ready, tx_busy, tx_line, rx_valid, rx_frame_err;
    logic [2:0]  rx_cmd;
    logic [75:0] rx_data;
    logic [6:0]  rx_len;
    logic        rx_line;
    int          total = 0;
    int          bad = 0;
    bit          finished = 1'b0;

    always #10 clk = ~clk;
    assign rx_line = man_sel ? man_line : tx_line;

    syncmsg_link uut (
        .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_cmd(tx_cmd), .tx_data(tx_data), .tx_busy(tx_busy), .tx_line(tx_line),
        .rx_line(rx_line), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rx_cmd(rx_cmd), .rx_data(rx_data), .rx_len(rx_len),
        .rx_frame_err(rx_frame_err)
    );

    localparam int NV = 6;
    localparam logic [2:0] V_OP [NV] = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b100, 3'b101};
    localparam logic [75:0] V_DATA [NV] = '{
        76'hF_FFFF_FFFF_FFFF_FFFF_FF, 76'hE_0123_4567_89AB_CDEF_12,
        76'h1_1111_2222_3333_4444_A5, 76'hC_3A5F_0F1E_2D3C_4B5A_69,
        76'h7_7777_7777_7777_7777_3D, 76'h5_5555_AAAA_5555_AAAA_C3};
    localparam int V_LEN [NV] = '{0, 32, 8, 76, 17, 8};

    task automatic check(input bit ok, input string req, input string what,
                         input logic [75:0] act, input logic [75:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [75:0] keep_low(input logic [75:0] v, input int n);
        logic [75:0] m;
        m = (n >= 76) ? '1 : ((76'(1) << n) - 76'(1));
        return v & m;
    endfunction

    task automatic put(input logic b);
        man_line = b;
        @(negedge clk);
    endtask

    task automatic put_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) put(b[i]);
    endtask

    task automatic ack();
        rx_ready = 1'b1;
        @(negedge clk);
        rx_ready = 1'b0;
    endtask

    // Called at a negedge with the transmitter idle; returns at the cycle rx_valid is seen.
    task automatic send(input logic [2:0] op, input logic [75:0] dat,
                        output int lat, output int busy_n, output bit start_ok);
        tx_cmd = op; tx_data = dat; tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        start_ok = tx_line && !tx_ready;
        lat = -1; busy_n = 0;
        for (int i = 0; i < 120; i++) begin
            if (tx_busy) busy_n++;
            if (rx_valid) begin lat = i; break; end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL R4 watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int lat, bn, hits;
        bit st;

        // R8: reset state, during and just after reset
        repeat (3) @(negedge clk);
        check(tx_ready && !tx_busy && !tx_line, "R8", "tx in reset", {tx_ready, tx_busy, tx_line}, 3'b100);
        check(!rx_valid && !rx_frame_err, "R8", "rx in reset", {rx_valid, rx_frame_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_ready && !tx_busy, "R8", "tx after reset", {tx_ready, tx_busy}, 2'b10);
        check(!tx_line, "R1", "idle line", tx_line, 0);
        @(negedge clk);

        // R5: reserved codes go out with no data and are dropped silently
        for (int r = 6; r < 8; r++) begin
            send(3'(r), '1, lat, bn, st);
            check(bn == 5, "R5", "reserved busy cycles", 76'(bn), 5);
            check(lat < 0, "R5", "reserved delivered", 76'(lat), 76'(-1));
            check(!rx_frame_err && !rx_valid, "R5", "reserved flags", {rx_frame_err, rx_valid}, 0);
            @(negedge clk);
        end

        // R2 R3 R4: vector table through the loopback
        for (int v = 0; v < NV; v++) begin
            send(V_OP[v], V_DATA[v], lat, bn, st);
            check(st, "R2", "start bit / ready low", 76'(st), 1);
            check(bn == 5 + V_LEN[v], "R2", "busy cycles", 76'(bn), 76'(5 + V_LEN[v]));
            check(lat == 5 + V_LEN[v], "R4", "latency", 76'(lat), 76'(5 + V_LEN[v]));
            check(rx_cmd == V_OP[v], "R3", "code", 76'(rx_cmd), 76'(V_OP[v]));
            check(rx_len == 7'(V_LEN[v]), "R3", "length", 76'(rx_len), 76'(V_LEN[v]));
            check(rx_data == keep_low(V_DATA[v], V_LEN[v]), "R4", "data", rx_data,
                  keep_low(V_DATA[v], V_LEN[v]));
            ack();
            check(!rx_valid, "R4", "valid cleared by ready", 76'(rx_valid), 0);
            check(!tx_line, "R1", "idle after frame", 76'(tx_line), 0);
        end

        // R2: an offer made while busy is ignored
        tx_cmd = 3'b100; tx_data = 76'h1_2345; tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        @(negedge clk);
        tx_cmd = 3'b011; tx_data = '1; tx_valid = 1'b1;
        @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
        for (int i = 0; i < 60 && !rx_valid; i++) @(negedge clk);
        check(rx_valid && rx_cmd == 3'b100, "R2", "first message kept", 76'(rx_cmd), 76'(3'b100));
        check(rx_data == 76'h1_2345, "R2", "first data kept", rx_data, 76'h1_2345);
        ack();
        hits = 0;
        repeat (100) begin
            if (rx_valid || tx_busy) hits++;
            @(negedge clk);
        end
        check(hits == 0, "R2", "busy-time offer not sent", 76'(hits), 0);

        // R4: message held while the consumer stalls
        send(3'b010, 76'h5A, lat, bn, st);
        repeat (20) @(negedge clk);
        check(rx_valid && rx_cmd == 3'b010 && rx_data == 76'h5A, "R4", "held under stall",
              rx_data, 76'h5A);
        ack();

        // R6 R7: hand-driven line
        man_sel = 1'b1;
        put(1'b0); put(1'b0);
        put(1'b1); put(1'b0); put(1'b1); put(1'b0);   // start, code 010
        put_byte(8'hA5);
        put(1'b1);                                     // bad stop bit
        check(rx_frame_err == 1'b1, "R6", "error pulse", 76'(rx_frame_err), 1);
        check(!rx_valid, "R6", "no message on bad stop", 76'(rx_valid), 0);
        hits = 0;
        repeat (30) begin
            put(1'b1);
            if (rx_valid || rx_frame_err) hits++;
        end
        check(hits == 0, "R7", "stuck-high line starts nothing", 76'(hits), 0);
        put(1'b0);
        put(1'b1); put(1'b1); put(1'b0); put(1'b1);   // start, code 101
        put_byte(8'h3C);
        put(1'b0);
        check(rx_valid && rx_cmd == 3'b101 && rx_len == 7'd8, "R7", "resync after idle",
              {rx_valid, rx_cmd, rx_len}, {1'b1, 3'b101, 7'd8});
        check(rx_data == 76'h3C, "R7", "resync data", rx_data, 76'h3C);
        ack();
        man_sel = 1'b0;

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule